// File: doc/BRIEF.md
# Memory-Mapped OS Timer Channel

A single timer channel with a counter of configurable width, reached through a small register interface. The interface takes one write or one read per cycle. Reads are combinational on the address. Software sets a compare value and picks a mode in a control register. It then starts and stops the channel by writing one to separate trigger locations, and polls a read-only enable-status bit to confirm that a start or stop has taken effect. The counter advances on every clock, which serves as the tick.

In interval mode, a start loads the counter from the compare value. The counter then counts down to zero and reloads. A compare value of N-1 therefore gives one interrupt pulse every N ticks. In free-run mode, a start clears the counter, and the counter then counts up and wraps. An interrupt pulse fires on the tick where the counter becomes equal to a non-zero compare value. The match does not stop the counter. The counter can be read at any time, so it can also serve as a monotonic time base. Each channel is an independent instance.

Register offsets, in bytes: compare 0x00, counter 0x04, enable status 0x10, start trigger 0x14, stop trigger 0x18, control 0x20.

Top module: `os_timer_channel`

## Requirements
- R1: After reset, the counter, compare, enable-status and control registers all read 0, and `irqPulse` is low.
- R2: A write to offset 0x14 with data bit 0 = 1 starts the channel, and bit 0 at offset 0x10 reads 1 from the next cycle.
- R3: A write to offset 0x18 with data bit 0 = 1 stops the channel, and bit 0 at offset 0x10 reads 0 from the next cycle.
- R4: With control bit 1 = 0 (interval mode), a start loads the counter with the compare value. The counter then decrements by one per clock. On the clock after it reads 0, it reloads the compare value and `irqPulse` is high for that cycle, so pulses are spaced compare+1 clocks apart.
- R5: With control bit 1 = 1 (free-run mode), a start clears the counter to 0. The counter then increments by one per clock and wraps from all-ones to 0.
- R6: In free-run mode, `irqPulse` is high for the cycle in which the counter equals a non-zero compare value, and the counter keeps counting afterwards. A compare value of 0 produces no pulse.
- R7: `irqPulse` is a single-cycle pulse per event.
- R8: A control write while the channel runs changes the value read back at 0x20, but the active mode stays as it was until the next start.
- R9: A write with data bit 0 = 0 to either trigger offset has no effect on the enable status or the counter.
- R10: Reads of offsets 0x14 and 0x18, and of any unmapped offset, return 0. Reads of offset 0x20 return only control bit 1, with all other bits 0.
- R11: While the channel is stopped, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regAddr | input | ADDR_W (6) | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The bench counts interval pulses over several reloads. A design that is off by one in the reload, or that stretches the pulse, shows a wrong pulse count or a wrong counter reading at a known cycle. It writes the control register mid-run and checks that the counter keeps moving down, so a design that switches mode at once shows up. It writes zero to both triggers, stops the channel one cycle after a known position, and runs a narrowed counter through a wrap with a compare of zero. These steps expose a design that triggers on any write, loses or keeps counting after a stop, saturates instead of wrapping, or fires a match at zero.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int BUS_W = 32;

  // register byte offsets
  localparam int OFS_CMP   = 'h00;
  localparam int OFS_CNT   = 'h04;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_START = 'h14;
  localparam int OFS_STOP  = 'h18;
  localparam int OFS_CTRL  = 'h20;

  // strobes from control to datapath
  typedef struct packed {
    logic cmpWr;     // load compare register
    logic loadCmp;   // interval start: counter <= compare
    logic clearCnt;  // free-run start: counter <= 0
    logic count;     // channel running
    logic freeMode;  // active mode latched at start
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wrLow,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  cmpVal,
  output tmrStrobe_t        strobe,
  output logic [BUS_W-1:0]  rdData
);
  logic running;
  logic activeFree;
  logic ctrlMode;

  logic hitCmp, hitStart, hitStop, hitCtrl;
  logic startHit, stopHit;

  assign hitCmp   = wrEn && (addr == ADDR_W'(OFS_CMP));
  assign hitStart = wrEn && (addr == ADDR_W'(OFS_START));
  assign hitStop  = wrEn && (addr == ADDR_W'(OFS_STOP));
  assign hitCtrl  = wrEn && (addr == ADDR_W'(OFS_CTRL));
  assign startHit = hitStart && wrLow[0];
  assign stopHit  = hitStop && wrLow[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running    <= 1'b0;
      activeFree <= 1'b0;
      ctrlMode   <= 1'b0;
    end else begin
      if (hitCtrl) ctrlMode <= wrLow[1];
      if (startHit) begin
        running    <= 1'b1;
        activeFree <= ctrlMode;
      end else if (stopHit) begin
        running <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.cmpWr    = hitCmp;
    strobe.loadCmp  = startHit && !ctrlMode;
    strobe.clearCnt = startHit && ctrlMode;
    strobe.count    = running;
    strobe.freeMode = activeFree;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(OFS_CMP):  rdData = BUS_W'(cmpVal);
      ADDR_W'(OFS_CNT):  rdData = BUS_W'(cntVal);
      ADDR_W'(OFS_STAT): rdData = BUS_W'(running);
      ADDR_W'(OFS_CTRL): rdData = BUS_W'({ctrlMode, 1'b0});
      default:           rdData = '0;
    endcase
  end

  // R2: start trigger sets the enable status
  p_start_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_START) && wrLow[0]) |=> running);
  // R3: stop trigger clears the enable status
  p_stop_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_STOP) && wrLow[0]) |=> !running);
  // R8: active mode only changes on a start
  p_mode_latched_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'(OFS_START)) |=> $stable(activeFree));
  // R9: zero writes to triggers leave the status alone
  p_zero_trigger_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_W'(OFS_START) || addr == ADDR_W'(OFS_STOP)) && !wrLow[0])
      |=> $stable(running));
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic             irqPulse
);
  logic [CNT_W-1:0] cntInc;
  assign cntInc = cntVal + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal   <= '0;
      cmpVal   <= '0;
      irqPulse <= 1'b0;
    end else begin
      if (strobe.cmpWr) cmpVal <= wrData;
      irqPulse <= 1'b0;
      if (strobe.loadCmp) begin
        cntVal <= cmpVal;
      end else if (strobe.clearCnt) begin
        cntVal <= '0;
      end else if (strobe.count) begin
        if (strobe.freeMode) begin
          cntVal   <= cntInc;
          irqPulse <= (cntInc == cmpVal) && (cmpVal != '0);
        end else if (cntVal == '0) begin
          cntVal   <= cmpVal;
          irqPulse <= 1'b1;
        end else begin
          cntVal <= cntVal - CNT_W'(1);
        end
      end
    end
  end

  // R4: interval reload at zero with a pulse
  p_interval_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.count && !strobe.freeMode && !strobe.loadCmp && !strobe.clearCnt && cntVal == '0)
      |=> (cntVal == $past(cmpVal)) && irqPulse);
  // R5: free-run counts up by one
  p_free_inc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.count && strobe.freeMode && !strobe.loadCmp && !strobe.clearCnt)
      |=> cntVal == $past(cntVal) + CNT_W'(1));
  // R7: pulse lasts one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && cmpVal != '0 && $stable(cmpVal) && !strobe.cmpWr) |=> !irqPulse);
  // R11: stopped counter holds
  p_hold_stopped_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.count && !strobe.loadCmp && !strobe.clearCnt) |=> $stable(cntVal));
endmodule

// File: rtl/os_timer_channel.sv
module os_timer_channel
  import timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  output logic              irqPulse
);
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;

  timer_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .wrLow  (regWrData[1:0]),
    .cntVal (cntVal),
    .cmpVal (cmpVal),
    .strobe (strobe),
    .rdData (regRdData)
  );

  timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData[CNT_W-1:0]),
    .cntVal   (cntVal),
    .cmpVal   (cmpVal),
    .irqPulse (irqPulse)
  );
endmodule

// File: tb/os_timer_channel_tb.sv
`timescale 1ns/100ps
module os_timer_channel_tb;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic              irqPulse;
  logic              rdReq = 1'b0;

  int checks = 0;
  int failures = 0;
  int irqCount = 0;
  int irqBase;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } expItem_t;
  expItem_t expQ[$];

  os_timer_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqPulse(irqPulse)
  );

  always #2.5 clk = ~clk;

  // monitor: pops expected read items and counts interrupt pulses
  always @(negedge clk) begin
    if (irqPulse) irqCount++;
    if (rdReq) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (regRdData !== it.exp) begin
        failures++;
        $display("FAIL %s read addr 0x%0h actual=0x%0h expected=0x%0h",
                 it.req, regAddr, regRdData, it.exp);
      end
    end
  end

  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string req);
    regAddr = a;
    expQ.push_back('{exp: e, req: req});
    rdReq = 1'b1;
    @(negedge clk); #1;
    rdReq = 1'b0;
  endtask

  task automatic checkVal(input int act, input int e, input string req);
    checks++;
    if (act != e) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    // R1 reset state
    checkVal(int'(irqPulse), 0, "R1 irq");
    regRead(6'h04, 0, "R1 counter");
    regRead(6'h00, 0, "R1 compare");
    regRead(6'h10, 0, "R1 status");
    regRead(6'h20, 0, "R1 control");

    // R10 read-only and masked reads
    regWrite(6'h20, 32'hFF);
    regRead(6'h20, 32'h2, "R10 control mask");
    regRead(6'h14, 0, "R10 start reads 0");
    regRead(6'h18, 0, "R10 stop reads 0");
    regRead(6'h08, 0, "R10 unmapped");
    regWrite(6'h20, 32'h0);

    // R9 start with bit0 clear is ignored
    regWrite(6'h14, 32'hFE);
    regRead(6'h10, 0, "R9 start zero status");
    regRead(6'h04, 0, "R9 start zero counter");

    // R4 interval mode, compare 15 -> period 16
    regWrite(6'h00, 32'd15);
    regRead(6'h00, 32'd15, "R4 compare readback");
    regWrite(6'h14, 32'h1);
    irqBase = irqCount;
    regRead(6'h04, 32'd15, "R4 load on start");
    regRead(6'h10, 32'h1, "R2 status after start");
    repeat (48) @(posedge clk); #1;
    checkVal(irqCount - irqBase, 3, "R4 R7 interval pulses");
    regRead(6'h04, 32'd14, "R4 count after reloads");
    regWrite(6'h18, 32'h0);
    regRead(6'h10, 32'h1, "R9 stop zero ignored");
    regWrite(6'h18, 32'h1);
    regRead(6'h10, 0, "R3 status after stop");
    regRead(6'h04, 32'd10, "R3 counter at stop");
    repeat (5) @(posedge clk); #1;
    regRead(6'h04, 32'd10, "R11 counter held");

    // R5/R6 free-run with compare 20
    regWrite(6'h00, 32'd20);
    regWrite(6'h20, 32'h2);
    regWrite(6'h14, 32'h1);
    irqBase = irqCount;
    repeat (30) @(posedge clk); #1;
    regRead(6'h04, 32'd30, "R5 R6 counts past match");
    checkVal(irqCount - irqBase, 1, "R6 one match pulse");
    regWrite(6'h18, 32'h1);
    regRead(6'h04, 32'd32, "R3 free counter at stop");

    // R8 control write while running does not switch mode
    regWrite(6'h20, 32'h0);
    regWrite(6'h00, 32'd15);
    regWrite(6'h14, 32'h1);
    regWrite(6'h20, 32'h2);
    regRead(6'h04, 32'd13, "R8 still counting down");
    regRead(6'h20, 32'h2, "R8 control readback");
    regWrite(6'h14, 32'h1);
    regRead(6'h04, 0, "R8 new mode on restart");
    regWrite(6'h18, 32'h1);

    // R5/R6 wrap with compare 0, no pulses
    regWrite(6'h00, 32'd0);
    regWrite(6'h14, 32'h1);
    irqBase = irqCount;
    repeat (4100) @(posedge clk); #1;
    regRead(6'h04, 32'd4, "R5 wrap");
    checkVal(irqCount - irqBase, 0, "R6 compare zero no pulse");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule